// File: doc/BRIEF.md
# Variable Range Slot Encoder and Checker

This block manages a small bank of variable memory-range slots. Each slot holds a pair of words: a base word and a mask word. A requester describes a region by its page number, its size in pages and a memory type. The block turns that description into the word pair and stores it in the chosen slot. It can also turn a stored pair back into page, size and type, check whether a region is naturally aligned to its size, and pick a slot for a new region.

Requests arrive on a single command port carrying an op code and its operands. Encode, decode and slot search finish in one cycle. Each of them raises `done` for a single cycle with `err` beside it. The alignment check runs as an iterative loop, one shift per cycle, and holds `busy` high until it finishes. While `busy` is high, new commands are dropped.

Top module: `rv_slot_ctl`

## Requirements
- R1: Op code 0 (encode) stores into slot `cmd_slot` a base word equal to `cmd_base` shifted left by PG_SH bits, with `cmd_type` in bits PG_SH-1:0. A later decode of that slot returns `cmd_base` and `cmd_type`.
- R2: For a nonzero size, encode stores a mask word equal to the two's-complement negative of `cmd_size`, shifted left by PG_SH bits, with bit PG_SH-1 set as the valid flag.
- R3: Encode with a size of zero writes zero to both the mask word and the base word, so the valid flag is cleared. A later decode returns all zeros, and slot search treats the slot as free.
- R4: Op code 1 (decode) reports page, size and type as zero for a slot whose valid flag is clear. This includes every slot after reset.
- R5: On decode, let M be the page part of the mask word. If M is nonzero, every bit of M above its highest set bit is forced to one. `repaired` is raised when this changes M. The reported size is the negation of the filled M.
- R6: Encode raises `changed` if and only if the new word pair differs from the stored pair. The comparison ignores base bits 11:8 and mask bits 10:0.
- R7: Op code 2 (validate) computes last = base+size-1 modulo 2^PG_W. While the low bit of base is 0 and the low bit of last is 1, both are shifted right by one each cycle. `err` is 0 only if the two values end up equal. `done` arrives n+1 cycles after acceptance, where n is the number of shifts (n is at most PG_W).
- R8: `done` is high for exactly one cycle per accepted command. `busy` stays high from acceptance of a validate until its `done`. A command presented while `busy` is high is ignored and leaves the slots unchanged.
- R9: Op code 3 (find-free) returns `cmd_repl` in `rsp_slot` when bit SLOT_W of `cmd_repl` is 0. Otherwise it returns the lowest slot whose decoded size is zero. If no such slot exists, it sets `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 0 encode, 1 decode, 2 validate, 3 find-free |
| cmd_slot | input | SLOT_W | Slot for encode and decode |
| cmd_repl | input | SLOT_W+1 | Replacement slot for find-free; the top bit set means none |
| cmd_base | input | ADDR_W-PG_SH | Region start page |
| cmd_size | input | ADDR_W-PG_SH | Region size in pages |
| cmd_type | input | TYPE_W | Memory type code |
| busy | output | 1 | Validate loop in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Illegal region or no free slot |
| changed | output | 1 | Encode altered the stored pair |
| repaired | output | 1 | Decode filled the mask |
| rsp_base | output | ADDR_W-PG_SH | Decoded start page |
| rsp_size | output | ADDR_W-PG_SH | Decoded size in pages |
| rsp_type | output | TYPE_W | Decoded type |
| rsp_slot | output | SLOT_W | Slot written, read or found |

## Verification
The bench builds the block with its default parameters: eight slots, a 32-bit address, a 12-bit page shift and a 12-bit type field. Because the page field is 20 bits wide, any size above 2^19 that is not a power of two yields a mask with a zero top bit, which exercises the repair path. The full 12-bit type lets type bits 11:8 change while `changed` must stay low. Eight slots are few enough to fill, so the no-space error is reachable. A zero base with zero size drives the validate loop through all 20 shifts.

// File: rtl/rv_pkg.sv
package rv_pkg;
    typedef enum logic [1:0] {
        RV_ENC  = 2'd0,
        RV_DEC  = 2'd1,
        RV_VAL  = 2'd2,
        RV_FREE = 2'd3
    } rv_op_e;
endpackage

// File: rtl/rv_encode.sv
module rv_encode #(
    parameter int PG_W   = 20,
    parameter int PG_SH  = 12,
    parameter int TYPE_W = 12
) (
    input  logic [PG_W-1:0]       page,
    input  logic [PG_W-1:0]       size,
    input  logic [TYPE_W-1:0]     typ,
    output logic [PG_W+PG_SH-1:0] base_w,
    output logic [PG_W+PG_SH-1:0] mask_w
);
    localparam int WW = PG_W + PG_SH;

    always_comb begin
        base_w = '0;
        mask_w = '0;
        if (size != '0) begin
            base_w[WW-1:PG_SH]    = page;
            base_w[TYPE_W-1:0]    = typ;
            mask_w[WW-1:PG_SH]    = PG_W'(0) - size;
            mask_w[PG_SH-1]       = 1'b1;
        end
    end
endmodule

// File: rtl/rv_decode.sv
module rv_decode #(
    parameter int PG_W   = 20,
    parameter int TYPE_W = 12
) (
    input  logic              vld,
    input  logic [PG_W-1:0]   base_pg,
    input  logic [TYPE_W-1:0] base_ty,
    input  logic [PG_W-1:0]   mask_pg,
    output logic [PG_W-1:0]   page,
    output logic [PG_W-1:0]   size,
    output logic [TYPE_W-1:0] typ,
    output logic              repair
);
    logic [PG_W-1:0] fill;

    always_comb begin
        logic hit;
        hit  = 1'b0;
        fill = mask_pg;
        for (int i = PG_W - 1; i >= 0; i--) begin
            if (!hit) begin
                if (mask_pg[i]) hit = 1'b1;
                else            fill[i] = 1'b1;
            end
        end
        if (mask_pg == '0) fill = '0;
    end

    always_comb begin
        page   = '0;
        size   = '0;
        typ    = '0;
        repair = 1'b0;
        if (vld) begin
            page   = base_pg;
            typ    = base_ty;
            size   = PG_W'(0) - fill;
            repair = (fill != mask_pg);
        end
    end
endmodule

// File: rtl/rv_first_free.sv
module rv_first_free #(
    parameter int SLOT_W = 3
) (
    input  logic [(1<<SLOT_W)-1:0] free_v,
    output logic                   found,
    output logic [SLOT_W-1:0]      idx
);
    localparam int NSLOT = 1 << SLOT_W;

    always_comb begin
        idx   = '0;
        found = |free_v;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (free_v[i]) idx = SLOT_W'(i);
        end
    end
endmodule

// File: rtl/rv_slot_ctl.sv
module rv_slot_ctl #(
    parameter int SLOT_W = 3,
    parameter int ADDR_W = 32,
    parameter int PG_SH  = 12,
    parameter int TYPE_W = 12
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    input  logic [1:0]              cmd_op,
    input  logic [SLOT_W-1:0]       cmd_slot,
    input  logic [SLOT_W:0]         cmd_repl,
    input  logic [ADDR_W-PG_SH-1:0] cmd_base,
    input  logic [ADDR_W-PG_SH-1:0] cmd_size,
    input  logic [TYPE_W-1:0]       cmd_type,
    output logic                    busy,
    output logic                    done,
    output logic                    err,
    output logic                    changed,
    output logic                    repaired,
    output logic [ADDR_W-PG_SH-1:0] rsp_base,
    output logic [ADDR_W-PG_SH-1:0] rsp_size,
    output logic [TYPE_W-1:0]       rsp_type,
    output logic [SLOT_W-1:0]       rsp_slot
);
    import rv_pkg::*;

    localparam int NSLOT = 1 << SLOT_W;
    localparam int PG_W  = ADDR_W - PG_SH;
    localparam logic [ADDR_W-1:0] BASE_CMP = ~(ADDR_W'(15) << (PG_SH - 4));
    localparam logic [ADDR_W-1:0] MASK_CMP = ~((ADDR_W'(1) << (PG_SH - 1)) - ADDR_W'(1));

    typedef struct packed {
        logic              busy;
        logic              done;
        logic              err;
        logic              chg;
        logic              rep;
        logic [PG_W-1:0]   rbase;
        logic [PG_W-1:0]   rsize;
        logic [TYPE_W-1:0] rtype;
        logic [SLOT_W-1:0] rslot;
        logic [PG_W-1:0]   vb;
        logic [PG_W-1:0]   vl;
    } ctl_t;

    ctl_t st_d, st_q;
    logic [ADDR_W-1:0] base_q [NSLOT];
    logic [ADDR_W-1:0] base_d [NSLOT];
    logic [ADDR_W-1:0] mask_q [NSLOT];
    logic [ADDR_W-1:0] mask_d [NSLOT];

    logic [ADDR_W-1:0] enc_base, enc_mask;
    logic [PG_W-1:0]   dpage [NSLOT];
    logic [PG_W-1:0]   dsize [NSLOT];
    logic [TYPE_W-1:0] dtype [NSLOT];
    logic [NSLOT-1:0]  drep;
    logic [NSLOT-1:0]  free_v;
    logic              free_found;
    logic [SLOT_W-1:0] free_idx;

    rv_encode #(.PG_W(PG_W), .PG_SH(PG_SH), .TYPE_W(TYPE_W)) u_enc (
        .page   (cmd_base),
        .size   (cmd_size),
        .typ    (cmd_type),
        .base_w (enc_base),
        .mask_w (enc_mask)
    );

    for (genvar g = 0; g < NSLOT; g++) begin : g_dec
        rv_decode #(.PG_W(PG_W), .TYPE_W(TYPE_W)) u_dec (
            .vld     (mask_q[g][PG_SH-1]),
            .base_pg (base_q[g][ADDR_W-1:PG_SH]),
            .base_ty (base_q[g][TYPE_W-1:0]),
            .mask_pg (mask_q[g][ADDR_W-1:PG_SH]),
            .page    (dpage[g]),
            .size    (dsize[g]),
            .typ     (dtype[g]),
            .repair  (drep[g])
        );
        assign free_v[g] = (dsize[g] == '0);
    end

    rv_first_free #(.SLOT_W(SLOT_W)) u_free (
        .free_v (free_v),
        .found  (free_found),
        .idx    (free_idx)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        for (int i = 0; i < NSLOT; i++) begin
            base_d[i] = base_q[i];
            mask_d[i] = mask_q[i];
        end
        if (st_q.busy) begin
            if (!st_q.vb[0] && st_q.vl[0]) begin
                st_d.vb = st_q.vb >> 1;
                st_d.vl = st_q.vl >> 1;
            end else begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                st_d.err  = (st_q.vb != st_q.vl);
            end
        end else if (cmd_valid) begin
            st_d.chg = 1'b0;
            st_d.rep = 1'b0;
            st_d.err = 1'b0;
            case (rv_op_e'(cmd_op))
                RV_ENC: begin
                    st_d.chg = (((enc_base ^ base_q[cmd_slot]) & BASE_CMP) != '0) ||
                               (((enc_mask ^ mask_q[cmd_slot]) & MASK_CMP) != '0);
                    base_d[cmd_slot] = enc_base;
                    mask_d[cmd_slot] = enc_mask;
                    st_d.rslot = cmd_slot;
                    st_d.done  = 1'b1;
                end
                RV_DEC: begin
                    st_d.rbase = dpage[cmd_slot];
                    st_d.rsize = dsize[cmd_slot];
                    st_d.rtype = dtype[cmd_slot];
                    st_d.rep   = drep[cmd_slot];
                    st_d.rslot = cmd_slot;
                    st_d.done  = 1'b1;
                end
                RV_VAL: begin
                    st_d.busy = 1'b1;
                    st_d.vb   = cmd_base;
                    st_d.vl   = cmd_base + cmd_size - PG_W'(1);
                end
                default: begin
                    if (!cmd_repl[SLOT_W]) begin
                        st_d.rslot = cmd_repl[SLOT_W-1:0];
                    end else if (free_found) begin
                        st_d.rslot = free_idx;
                    end else begin
                        st_d.rslot = '0;
                        st_d.err   = 1'b1;
                    end
                    st_d.done = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
            for (int i = 0; i < NSLOT; i++) begin
                base_q[i] <= '0;
                mask_q[i] <= '0;
            end
        end else begin
            st_q <= st_d;
            for (int i = 0; i < NSLOT; i++) begin
                base_q[i] <= base_d[i];
                mask_q[i] <= mask_d[i];
            end
        end
    end

    assign busy     = st_q.busy;
    assign done     = st_q.done;
    assign err      = st_q.err;
    assign changed  = st_q.chg;
    assign repaired = st_q.rep;
    assign rsp_base = st_q.rbase;
    assign rsp_size = st_q.rsize;
    assign rsp_type = st_q.rtype;
    assign rsp_slot = st_q.rslot;
endmodule

// File: rtl/rv_slot_ctl_chk.sv
module rv_slot_ctl_chk #(
    parameter int SLOT_W = 3,
    parameter int ADDR_W = 32,
    parameter int PG_SH  = 12
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cmd_valid,
    input logic [1:0]              cmd_op,
    input logic [SLOT_W-1:0]       cmd_slot,
    input logic [SLOT_W:0]         cmd_repl,
    input logic [ADDR_W-PG_SH-1:0] cmd_size,
    input logic                    busy,
    input logic                    done,
    input logic                    err,
    input logic [SLOT_W-1:0]       rsp_slot,
    input logic [ADDR_W-1:0]       mask_q [1<<SLOT_W]
);
    localparam int PG_W = ADDR_W - PG_SH;
    localparam int CW   = $clog2(PG_W + 2) + 1;

    logic [CW-1:0] vcnt_q;
    logic          take;

    assign take = cmd_valid && !busy;

    always_ff @(posedge clk) begin
        if (!rst_n)    vcnt_q <= '0;
        else if (busy) vcnt_q <= vcnt_q + CW'(1);
        else           vcnt_q <= '0;
    end

    a_r7_loop_bound: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> vcnt_q <= CW'(PG_W));

    a_r8_done_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !take) |=> !done);

    a_r9_repl_direct: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cmd_op == 2'd3 && !cmd_repl[SLOT_W])
        |=> (done && !err && rsp_slot == $past(cmd_repl[SLOT_W-1:0])));

    a_r2_valid_set: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cmd_op == 2'd0 && cmd_size != '0)
        |=> mask_q[$past(cmd_slot)][PG_SH-1]);

    a_r3_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (take && cmd_op == 2'd0 && cmd_size == '0)
        |=> mask_q[$past(cmd_slot)] == '0);
endmodule

bind rv_slot_ctl rv_slot_ctl_chk #(
    .SLOT_W (SLOT_W),
    .ADDR_W (ADDR_W),
    .PG_SH  (PG_SH)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_op    (cmd_op),
    .cmd_slot  (cmd_slot),
    .cmd_repl  (cmd_repl),
    .cmd_size  (cmd_size),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .rsp_slot  (rsp_slot),
    .mask_q    (mask_q)
);

// File: tb/rv_slot_ctl_tb.sv
module rv_slot_ctl_tb;
    localparam int PG_W = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [2:0]  cmd_slot = '0;
    logic [3:0]  cmd_repl = '0;
    logic [19:0] cmd_base = '0;
    logic [19:0] cmd_size = '0;
    logic [11:0] cmd_type = '0;
    logic        busy, done, err, changed, repaired;
    logic [19:0] rsp_base, rsp_size;
    logic [11:0] rsp_type;
    logic [2:0]  rsp_slot;

    int n_chk = 0;
    int n_err = 0;

    logic [31:0] mb [8];
    logic [31:0] mm [8];

    always #5 clk = ~clk;

    rv_slot_ctl u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_slot(cmd_slot), .cmd_repl(cmd_repl), .cmd_base(cmd_base),
        .cmd_size(cmd_size), .cmd_type(cmd_type), .busy(busy), .done(done),
        .err(err), .changed(changed), .repaired(repaired), .rsp_base(rsp_base),
        .rsp_size(rsp_size), .rsp_type(rsp_type), .rsp_slot(rsp_slot)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    function automatic logic [31:0] m_base(input logic [19:0] pg, input logic [19:0] sz, input logic [11:0] ty);
        return (sz == 0) ? 32'h0 : {pg, ty};
    endfunction

    function automatic logic [31:0] m_mask(input logic [19:0] sz);
        logic [19:0] n;
        n = 20'h0 - sz;
        return (sz == 0) ? 32'h0 : {n, 12'h800};
    endfunction

    function automatic void m_dec(input logic [31:0] b, input logic [31:0] m,
                                  output logic [19:0] pg, output logic [19:0] sz,
                                  output logic [11:0] ty, output bit rp);
        logic [19:0] t, f;
        pg = '0; sz = '0; ty = '0; rp = 1'b0;
        if (m[11]) begin
            t = m[31:12];
            f = t;
            if (t != 0) begin
                for (int i = 19; i >= 0; i--) begin
                    if (t[i]) break;
                    f[i] = 1'b1;
                end
            end
            rp = (f != t);
            sz = 20'h0 - f;
            pg = b[31:12];
            ty = b[11:0];
        end
    endfunction

    function automatic int m_shifts(input logic [19:0] b, input logic [19:0] s, output bit legal);
        logic [19:0] x, y;
        int n;
        x = b; y = b + s - 20'd1; n = 0;
        while (!x[0] && y[0]) begin
            x = x >> 1; y = y >> 1; n++;
        end
        legal = (x == y);
        return n;
    endfunction

    function automatic int m_free(input logic [3:0] repl, output bit ok);
        logic [19:0] pg, sz; logic [11:0] ty; bit rp;
        ok = 1'b1;
        if (!repl[3]) return int'(repl[2:0]);
        for (int i = 0; i < 8; i++) begin
            m_dec(mb[i], mm[i], pg, sz, ty, rp);
            if (sz == 0) return i;
        end
        ok = 1'b0;
        return 0;
    endfunction

    task automatic issue(input logic [1:0] op, input logic [2:0] slot, input logic [3:0] repl,
                         input logic [19:0] base, input logic [19:0] size, input logic [11:0] ty,
                         output int lat);
        @(negedge clk);
        cmd_op = op; cmd_slot = slot; cmd_repl = repl;
        cmd_base = base; cmd_size = size; cmd_type = ty; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        lat = 1;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic do_enc(input logic [2:0] s, input logic [19:0] pg, input logic [19:0] sz, input logic [11:0] ty);
        int lat;
        logic [31:0] nb, nm;
        bit ec;
        nb = m_base(pg, sz, ty);
        nm = m_mask(sz);
        ec = (((nb ^ mb[s]) & 32'hFFFFF0FF) != 0) || (((nm ^ mm[s]) & 32'hFFFFF800) != 0);
        issue(2'd0, s, 4'd0, pg, sz, ty, lat);
        chk(lat == 1 && done, "R8 encode done latency", 64'(lat), 64'd1);
        chk(changed == ec, "R6 changed flag", 64'(changed), 64'(ec));
        mb[s] = nb; mm[s] = nm;
    endtask

    task automatic do_dec(input logic [2:0] s, input string req);
        int lat;
        logic [19:0] pg, sz; logic [11:0] ty; bit rp;
        m_dec(mb[s], mm[s], pg, sz, ty, rp);
        issue(2'd1, s, 4'd0, 20'd0, 20'd0, 12'd0, lat);
        chk(lat == 1, {req, " decode latency"}, 64'(lat), 64'd1);
        chk(rsp_base == pg, {req, " R1 decoded base"}, 64'(rsp_base), 64'(pg));
        chk(rsp_size == sz, {req, " R2 R5 decoded size"}, 64'(rsp_size), 64'(sz));
        chk(rsp_type == ty, {req, " R1 decoded type"}, 64'(rsp_type), 64'(ty));
        chk(repaired == rp, {req, " R5 repair flag"}, 64'(repaired), 64'(rp));
    endtask

    task automatic do_val(input logic [19:0] b, input logic [19:0] s);
        int lat, n;
        bit lg;
        n = m_shifts(b, s, lg);
        issue(2'd2, 3'd0, 4'd0, b, s, 12'd0, lat);
        chk(lat == n + 2, "R7 validate latency", 64'(lat), 64'(n + 2));
        chk(err == !lg, "R7 validate verdict", 64'(err), 64'(!lg));
        @(negedge clk);
        chk(!done && !busy, "R8 done single cycle", 64'(done), 64'd0);
    endtask

    task automatic do_free(input logic [3:0] repl);
        int lat, ex;
        bit ok;
        ex = m_free(repl, ok);
        issue(2'd3, 3'd0, repl, 20'd0, 20'd0, 12'd0, lat);
        chk(err == !ok, "R9 find-free error", 64'(err), 64'(!ok));
        if (ok) chk(rsp_slot == 3'(ex), "R9 find-free slot", 64'(rsp_slot), 64'(ex));
    endtask

    function automatic logic [19:0] rnd_size();
        case ($urandom % 6)
            0:       return 20'd0;
            1, 2:    return 20'd1 << ($urandom % 20);
            3:       return 20'($urandom % 64);
            default: return 20'($urandom);
        endcase
    endfunction

    initial begin
        #(10 * 150000);
        n_err++;
        $display("FAIL watchdog expired actual=1 expected=0");
        report();
        $finish;
    end

    initial begin
        int lat;
        void'($urandom(32'd4711));
        for (int i = 0; i < 8; i++) begin mb[i] = '0; mm[i] = '0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !err, "R8 reset idle", 64'({busy, done, err}), 64'd0);

        do_dec(3'd0, "R4 reset slot");
        do_free(4'b1000);
        do_free(4'b0101);

        do_enc(3'd2, 20'h12345, 20'h10, 12'h006);
        do_dec(3'd2, "R1 R2 basic");
        do_enc(3'd2, 20'h12345, 20'h10, 12'h106);
        chk(changed == 1'b0, "R6 type bits 11:8 ignored", 64'(changed), 64'd0);
        do_dec(3'd2, "R6 readback");
        do_enc(3'd3, 20'h00000, 20'h80001, 12'h005);
        do_dec(3'd3, "R5 holed mask");
        chk(repaired == 1'b1 && rsp_size == 20'd1, "R5 filled size", 64'(rsp_size), 64'd1);
        do_enc(3'd2, 20'h12345, 20'h0, 12'h006);
        do_dec(3'd2, "R3 cleared slot");
        do_dec(3'd7, "R4 untouched slot");

        for (int i = 0; i < 8; i++) do_enc(3'(i), 20'(i * 16), 20'h10, 12'h001);
        do_free(4'b1000);
        chk(err == 1'b1, "R9 no space", 64'(err), 64'd1);
        do_enc(3'd5, 20'h0, 20'h0, 12'h0);
        do_free(4'b1000);
        chk(rsp_slot == 3'd5, "R9 lowest free", 64'(rsp_slot), 64'd5);

        do_val(20'h00100, 20'h00100);
        do_val(20'h00100, 20'h00200);
        do_val(20'h00000, 20'h00000);
        do_val(20'h00003, 20'h00001);

        // R8: a command during the validate loop is dropped
        @(negedge clk);
        cmd_op = 2'd2; cmd_base = 20'h0; cmd_size = 20'h0; cmd_valid = 1'b1;
        @(negedge clk);
        chk(busy == 1'b1, "R8 busy during validate", 64'(busy), 64'd1);
        cmd_op = 2'd0; cmd_slot = 3'd1; cmd_base = 20'hABCDE; cmd_size = 20'h4; cmd_type = 12'h7;
        @(negedge clk);
        cmd_valid = 1'b0;
        lat = 0;
        while (!done && lat < 100) begin @(negedge clk); lat++; end
        chk(done == 1'b1, "R8 validate completes", 64'(done), 64'd1);
        do_dec(3'd1, "R8 ignored while busy");

        for (int k = 0; k < 400; k++) begin
            logic [2:0] s;
            s = 3'($urandom % 8);
            case ($urandom % 4)
                0: do_enc(s, 20'($urandom), rnd_size(), 12'($urandom));
                1: do_dec(s, "random");
                2: begin
                    logic [19:0] sz, bs;
                    sz = rnd_size();
                    bs = 20'($urandom);
                    if ($urandom % 2 == 0) bs = bs & ~(sz - 20'd1);
                    do_val(bs, sz);
                end
                default: do_free(4'($urandom % 16));
            endcase
        end

        repeat (2) @(negedge clk);
        report();
        $finish;
    end
endmodule